// File: doc/BRIEF.md
# Flash Write-Cycle Qualification Front-End

This block sits at the pin side of a parallel NOR-flash-style device model and runs entirely in one fast system clock. It samples the active-low chip enable, write enable and output enable, the address and data buses, and a supply-lockout flag. From these it decides when a real bus write has taken place and hands the command decoder a single-clock strobe with the address and data captured for that write.

Each control pin passes through a two-flop synchronizer and then a persistence filter. A level change only counts once it has been seen for `GLITCH_CYC` consecutive clocks, so short noise pulses cannot open or close a write. A write is open while chip enable and write enable are both low and output enable is high.

The address is taken at the moment the later of the two enables goes low. The data is taken at the moment the earlier of the two goes high. Writes are refused while the supply is locked out, during the settling period after reset, and for any write that was already open when power came up or when a lockout ended. During lockout the decoder is also held in reset.

Top module: `flash_wr_qual`

## Requirements
- R1: A write that opens (filtered chip enable low, write enable low, output enable high) and closes because chip enable or write enable rises, with output enable still high, produces exactly one `wr_stb` pulse, one clock wide.
- R2: No strobe is produced by enable activity while chip enable stays high, by enable activity while output enable is low, or by a write that output enable aborts by going low before either enable rises.
- R3: `wr_addr` carries the address bus value present when the later of chip enable and write enable went low, whichever of the two fell first.
- R4: `wr_data` carries the data bus value present when the earlier of chip enable and write enable went high. Later data changes before the other enable rises are not used.
- R5: Either of these is rejected: a low pulse on a control pin lasting fewer than `GLITCH_CYC` clock samples, or a high pulse within an open write lasting fewer than `GLITCH_CYC` samples. A rejected pulse neither opens, closes nor splits a write. A low write-enable pulse of exactly `GLITCH_CYC` samples is accepted as a write.
- R6: While `lockout` is high, `cmd_rst` is high and no strobe is issued. A write already open when lockout ends produces no strobe. `cmd_rst` is high out of reset.
- R7: If chip enable and write enable are low and output enable is high when reset is released, the write that ends when write enable first rises produces no strobe. The next full write is accepted.
- R8: `wr_addr` and `wr_data` change only in the cycle in which `wr_stb` is high, and are zero after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| addr | input | AW | Address bus |
| din | input | DW | Data bus |
| lockout | input | 1 | Supply-low lockout flag, active high |
| wr_stb | output | 1 | One-cycle write strobe to the command decoder |
| wr_addr | output | AW | Address captured for the strobed write |
| wr_data | output | DW | Data captured for the strobed write |
| cmd_rst | output | 1 | Reset request to the command logic |

## Verification
Four things are checked on every cycle by assertions:
- the strobe is one clock wide;
- it fires only when output enable was high and at least one enable had risen;
- a filtered control only moves to a level that the synchronizer has already shown;
- lockout always forces `cmd_rst` and suppresses the strobe, and the captured address and data hold still between strobes.

Other properties involve orderings across many clocks, so only the bench scenarios can show them:
- which bus value lands in the address and which in the data for each order of enable edges;
- that sub-threshold pulses are dropped while threshold-length ones pass;
- that a write straddling power-up or the end of lockout is discarded.

// File: rtl/flash_wr_qual.sv
module flash_wr_qual #(
  parameter int AW = 18,
  parameter int DW = 16,
  parameter int GLITCH_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          lockout,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          cmd_rst
);
  localparam int CW     = (GLITCH_CYC < 2) ? 1 : $clog2(GLITCH_CYC);
  localparam int SETTLE = GLITCH_CYC + 4;
  localparam int SW     = $clog2(SETTLE + 1);

  // index 0 chip enable, 1 write enable, 2 output enable, 3 lockout
  logic [3:0]    ctl_m, ctl_s;
  logic [2:0]    ctl_f;
  logic [CW-1:0] cnt [3];
  logic [AW-1:0] addr_m, addr_s, a_lat;
  logic [DW-1:0] din_m, din_s;
  logic [SW-1:0] settle_cnt;
  logic          settled, in_cyc, skip;

  wire lock_s = ctl_s[3];
  wire act    = ~ctl_f[0] & ~ctl_f[1] & ctl_f[2];
  wire hold   = lock_s | ~settled;

  assign settled = (settle_cnt == SW'(SETTLE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_m  <= 4'hF;
      ctl_s  <= 4'hF;
      addr_m <= '0;
      addr_s <= '0;
      din_m  <= '0;
      din_s  <= '0;
    end else begin
      ctl_m  <= {lockout, oe_n, we_n, ce_n};
      ctl_s  <= ctl_m;
      addr_m <= addr;
      addr_s <= addr_m;
      din_m  <= din;
      din_s  <= din_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_f <= 3'b111;
      for (int i = 0; i < 3; i++) cnt[i] <= '0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        if (ctl_s[i] != ctl_f[i]) begin
          if (cnt[i] == CW'(GLITCH_CYC - 1)) begin
            ctl_f[i] <= ctl_s[i];
            cnt[i]   <= '0;
          end else begin
            cnt[i] <= cnt[i] + 1'b1;
          end
        end else begin
          cnt[i] <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) settle_cnt <= '0;
    else if (!settled) settle_cnt <= settle_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cyc  <= 1'b0;
      skip    <= 1'b1;
      a_lat   <= '0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      cmd_rst <= 1'b1;
    end else begin
      wr_stb  <= 1'b0;
      cmd_rst <= lock_s;
      if (hold) begin
        in_cyc <= act;
        skip   <= 1'b1;
      end else if (!in_cyc && act) begin
        in_cyc <= 1'b1;
        skip   <= 1'b0;
        a_lat  <= addr_s;
      end else if (in_cyc && !act) begin
        in_cyc <= 1'b0;
        if (!skip && ctl_f[2]) begin
          wr_stb  <= 1'b1;
          wr_addr <= a_lat;
          wr_data <= din_s;
        end
      end
    end
  end
endmodule

// File: rtl/flash_wr_qual_chk.sv
module flash_wr_qual_chk #(
  parameter int AW = 18,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_stb,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          cmd_rst,
  input logic [3:0]    ctl_s,
  input logic [2:0]    ctl_f
);
  assert_stb_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  assert_stb_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(ctl_f[2]) && $past(ctl_f[0] || ctl_f[1]));

  assert_flt_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl_f[0]) |-> $past(ctl_s[0]) == ctl_f[0]);

  assert_flt_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl_f[1]) |-> $past(ctl_s[1]) == ctl_f[1]);

  assert_flt_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl_f[2]) |-> $past(ctl_s[2]) == ctl_f[2]);

  assert_lock_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_s[3] |=> cmd_rst && !wr_stb);

  assert_capture_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> $stable(wr_addr) && $stable(wr_data));
endmodule

bind flash_wr_qual flash_wr_qual_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
  .wr_data(wr_data), .cmd_rst(cmd_rst), .ctl_s(ctl_s), .ctl_f(ctl_f)
);

// File: tb/flash_wr_qual_tb.sv
module flash_wr_qual_tb;
  localparam int AW = 18;
  localparam int DW = 16;
  localparam int G  = 3;
  localparam int H  = G + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b0, we_n = 1'b0, oe_n = 1'b1, lockout = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic wr_stb, cmd_rst;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int checks = 0, errors = 0, n_stb = 0;
  logic [AW-1:0] last_a = '0;
  logic [DW-1:0] last_d = '0;

  always #4 clk = ~clk;

  flash_wr_qual #(.AW(AW), .DW(DW), .GLITCH_CYC(G)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .lockout(lockout), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .cmd_rst(cmd_rst)
  );

  always @(negedge clk) if (rst_n && wr_stb) begin
    n_stb++;
    last_a = wr_addr;
    last_d = wr_data;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] a_first, input logic [AW-1:0] a_second);
    return a_second;
  endfunction

  function automatic logic [DW-1:0] exp_data(input logic [DW-1:0] d_first, input logic [DW-1:0] d_second);
    return d_first;
  endfunction

  task automatic do_cycle(input bit ce_first, input bit ce_rise_first,
                          input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                          input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                          input bit abort, input bit expect_stb, input string req);
    int base;
    base = n_stb;
    addr = a0; din = d0; wt(H);
    if (ce_first) ce_n = 1'b0; else we_n = 1'b0;
    wt(H); addr = a1; wt(H);
    if (ce_first) we_n = 1'b0; else ce_n = 1'b0;
    wt(H);
    if (abort) begin oe_n = 1'b0; wt(H); end
    if (ce_rise_first) ce_n = 1'b1; else we_n = 1'b1;
    wt(H); din = d1; wt(H);
    ce_n = 1'b1; we_n = 1'b1;
    wt(H);
    oe_n = 1'b1;
    wt(H + 4);
    check({req, " strobe count"}, 64'(n_stb - base), expect_stb ? 64'd1 : 64'd0);
    if (expect_stb) begin
      check({req, " addr"}, 64'(last_a), 64'(exp_addr(a0, a1)));
      check({req, " data"}, 64'(last_d), 64'(exp_data(d0, d1)));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    // power-up with pins already in write state
    wt(3);
    check("R8 reset stb", 64'(wr_stb), 64'd0);
    check("R8 reset addr", 64'(wr_addr), 64'd0);
    check("R6 reset cmd_rst", 64'(cmd_rst), 64'd1);
    addr = 18'h1234; din = 16'hBEEF;
    rst_n = 1'b1;
    wt(20);
    check("R6 cmd_rst released", 64'(cmd_rst), 64'd0);
    we_n = 1'b1; wt(H); ce_n = 1'b1; wt(H + 4);
    check("R7 power-up write rejected", 64'(n_stb), 64'd0);
    do_cycle(1, 0, 18'h00AAA, 18'h00555, 16'h00A0, 16'h0055, 0, 1, "R7 next write accepted R1");

    // edge ordering
    do_cycle(1, 1, 18'h11111, 18'h22222, 16'h3333, 16'h4444, 0, 1, "R3 ce first R4 ce rise");
    do_cycle(0, 0, 18'h2A0F0, 18'h15F0F, 16'h9876, 16'h1111, 0, 1, "R3 we first R4 we rise");
    do_cycle(0, 1, 18'h3C3C3, 18'h03C3C, 16'hA5A5, 16'h5A5A, 0, 1, "R3 R4 mixed");

    // inhibits
    do_cycle(1, 0, 18'h0F00F, 18'h0BAD0, 16'hDEAD, 16'h0BAD, 1, 0, "R2 oe abort");
    check("R8 addr kept after abort", 64'(wr_addr), 64'h03C3C);
    check("R8 data kept after abort", 64'(wr_data), 64'hA5A5);
    base = n_stb;
    oe_n = 1'b0; wt(H); ce_n = 1'b0; we_n = 1'b0; wt(2 * H);
    ce_n = 1'b1; we_n = 1'b1; wt(H); oe_n = 1'b1; wt(H + 4);
    check("R2 oe low whole time", 64'(n_stb - base), 64'd0);
    for (int k = 0; k < 3; k++) begin we_n = 1'b0; wt(H); we_n = 1'b1; wt(H); end
    wt(4);
    check("R2 ce high blocks", 64'(n_stb - base), 64'd0);

    // glitch filtering
    addr = 18'h00777; din = 16'h7777;
    ce_n = 1'b0; wt(H);
    we_n = 1'b0; wt(G - 1); we_n = 1'b1; wt(2 * H);
    check("R5 short we pulse", 64'(n_stb - base), 64'd0);
    we_n = 1'b0; wt(G); we_n = 1'b1; wt(2 * H);
    check("R5 threshold we pulse", 64'(n_stb - base), 64'd1);
    check("R5 threshold addr", 64'(last_a), 64'h00777);
    ce_n = 1'b1; wt(H);
    we_n = 1'b0; wt(H);
    ce_n = 1'b0; wt(G - 1); ce_n = 1'b1; wt(2 * H);
    check("R5 short ce pulse", 64'(n_stb - base), 64'd1);
    ce_n = 1'b0; wt(2 * H);
    we_n = 1'b1; wt(G - 1); we_n = 1'b0; wt(2 * H);
    we_n = 1'b1; wt(H); ce_n = 1'b1; wt(H + 4);
    check("R5 high glitch inside write", 64'(n_stb - base), 64'd2);

    // lockout
    lockout = 1'b1; wt(6);
    check("R6 cmd_rst during lockout", 64'(cmd_rst), 64'd1);
    do_cycle(1, 0, 18'h01010, 18'h02020, 16'h1010, 16'h2020, 0, 0, "R6 write in lockout");
    base = n_stb;
    ce_n = 1'b0; we_n = 1'b0; wt(2 * H);
    lockout = 1'b0; wt(2 * H);
    check("R6 cmd_rst after lockout", 64'(cmd_rst), 64'd0);
    we_n = 1'b1; wt(H); ce_n = 1'b1; wt(H + 4);
    check("R6 straddling write dropped", 64'(n_stb - base), 64'd0);
    do_cycle(0, 1, 18'h30303, 18'h04040, 16'h3030, 16'h4040, 0, 1, "R6 write after lockout R1");

    // randomized writes
    begin
      int seed;
      seed = $urandom(32'h5EED);
      for (int k = 0; k < 40; k++) begin
        bit cf, rf, ab;
        logic [AW-1:0] a0, a1;
        logic [DW-1:0] d0, d1;
        cf = 1'($urandom); rf = 1'($urandom); ab = ($urandom % 5) == 0;
        a0 = AW'($urandom); a1 = AW'($urandom);
        d0 = DW'($urandom); d1 = DW'($urandom);
        do_cycle(cf, rf, a0, a1, d0, d1, ab, !ab, "R1 R3 R4 random");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule